// File: doc/BRIEF.md
# RTC Calendar Snapshot Sequencer

This block moves a whole calendar time between a system and a serial real-time-clock device in one uninterrupted sequence. It sits above a register access master that does the actual bit-level transfers: for every register touch it raises a request with direction, 4-bit address and 4-bit write data, then waits for a one-cycle acknowledge that also carries 4-bit read data. The sequencer owns the device's chip-enable line.

A command is a one-cycle `start` with `write` selecting direction. The block first gains access to the device. On each attempt it raises chip enable, writes the control register with a fixed base value, reads it back and looks at the busy bit. If the device is busy, chip enable drops for a fixed gap and a new attempt follows, up to a bounded number. Once access is gained, seconds, minutes, hours, day, month and year move as pairs of 4-bit BCD registers, ones before tens, and the weekday moves last as one raw nibble. Reads give binary values. Writes take binary values and convert them to BCD. A read is refused until a write has completed without error.

Top module: `rtc_snap_seq`

## Requirements
- R1: A read command while the time-valid flag is clear makes no register access, and `done` with `err`=1 follows one cycle after `start`. The flag is clear after reset.
- R2: Every access attempt raises `ce` and writes the control register (address 0xF) with the base value 0x2, then reads the control register.
- R3: When the control read returns bit 0 (busy) set, `ce` stays low for exactly `GAP_CYC` (250) clock cycles before the next attempt.
- R4: When `MAX_TRIES` (10) attempts all see busy, the command ends with `err`=1 after exactly 20 control accesses and no field access.
- R5: After a non-busy control read, 13 field accesses follow in this order: seconds, minutes, hours, day, month, year, each ones then tens, then weekday. The default addresses are ones/tens 0/1, 2/3, 4/5, 7/8, 9/A, B/C, and 6 for the weekday.
- R6: A read sets each binary output to tens×10+ones of the nibbles read, and the weekday output to the raw nibble.
- R7: A write sends the BCD ones digit to the ones register and the tens digit to the tens register. The year is first reduced modulo 100. The weekday is sent as the raw 4-bit value.
- R8: At the end of a command `done` is high for exactly one cycle, and `ce` is low in that cycle and after it.
- R9: A write ending without error sets the time-valid flag, so later reads proceed. A write ending in error leaves the flag unchanged.
- R10: `start` is ignored while a command is in progress.
- R11: While `acc_req` is high and not yet acknowledged, `acc_req`, `acc_wr`, `acc_addr` and `acc_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, one cycle |
| write | input | 1 | 1 = write time to device, 0 = read |
| wr_sec | input | 7 | Seconds to write, binary |
| wr_min | input | 7 | Minutes to write, binary |
| wr_hour | input | 7 | Hours to write, binary |
| wr_day | input | 7 | Day of month to write, binary |
| wr_mon | input | 7 | Month to write, binary |
| wr_year | input | 7 | Year to write, binary (taken modulo 100) |
| wr_wday | input | 4 | Weekday nibble to write |
| rd_sec | output | 7 | Seconds from the last transfer |
| rd_min | output | 7 | Minutes from the last transfer |
| rd_hour | output | 7 | Hours from the last transfer |
| rd_day | output | 7 | Day from the last transfer |
| rd_mon | output | 7 | Month from the last transfer |
| rd_year | output | 7 | Two-digit year from the last transfer |
| rd_wday | output | 4 | Weekday nibble from the last transfer |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Error status of the last command, valid with `done` |
| ce | output | 1 | Device chip enable |
| acc_req | output | 1 | Register access request to the access master |
| acc_wr | output | 1 | Access direction, 1 = write |
| acc_addr | output | 4 | Device register address |
| acc_wdata | output | 4 | Nibble to write |
| acc_done | input | 1 | One-cycle access acknowledge |
| acc_rdata | input | 4 | Nibble read, valid with `acc_done` |

## Verification
The assertions assume that the access master acknowledges only while a request is pending, with at most one `acc_done` per request, and that read nibbles are BCD digits so that tens×10+ones fits in 7 bits. The bench device model raises `acc_done` only after seeing `acc_req` with no acknowledge in flight, and it adds a random latency of zero to two cycles. Preloaded field registers get digits 0 to 9, and write values stay within calendar ranges except for one year above 99 that exercises the modulo rule.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int NUM_STEPS  = 2 * NUM_FIELDS + 1;

    typedef struct packed {
        logic [3:0] ctrl;
        logic [3:0] wday;
        logic [3:0] year10;
        logic [3:0] year1;
        logic [3:0] mon10;
        logic [3:0] mon1;
        logic [3:0] day10;
        logic [3:0] day1;
        logic [3:0] hour10;
        logic [3:0] hour1;
        logic [3:0] min10;
        logic [3:0] min1;
        logic [3:0] sec10;
        logic [3:0] sec1;
    } rtc_addr_map_t;

    localparam rtc_addr_map_t RTC_DEFAULT_MAP = '{
        ctrl: 4'hF, wday: 4'h6,
        year10: 4'hC, year1: 4'hB, mon10: 4'hA, mon1: 4'h9,
        day10: 4'h8, day1: 4'h7, hour10: 4'h5, hour1: 4'h4,
        min10: 4'h3, min1: 4'h2, sec10: 4'h1, sec1: 4'h0
    };

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [6:0] day;
        logic [6:0] mon;
        logic [6:0] year;
        logic [3:0] wday;
    } rtc_time_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL_WR,
        ST_CTRL_RD,
        ST_GAP,
        ST_XFER,
        ST_FINISH
    } seq_state_e;

    // binary to two BCD digits, tens in the upper nibble
    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] o;
        t = v / 7'd10;
        o = v % 7'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [3:0] tens, input logic [3:0] ones);
        logic [6:0] t;
        logic [6:0] o;
        t = {3'b000, tens};
        o = {3'b000, ones};
        return (t * 7'd10) + o;
    endfunction

endpackage

// File: rtl/rtc_step_map.sv
module rtc_step_map
    import rtc_snap_pkg::*;
#(
    parameter rtc_addr_map_t ADDR_MAP = RTC_DEFAULT_MAP
)(
    input  logic [3:0] step,
    output logic [3:0] addr
);

    // step order: field-major, ones before tens, weekday last
    always_comb begin
        case (step)
            4'd0:    addr = ADDR_MAP.sec1;
            4'd1:    addr = ADDR_MAP.sec10;
            4'd2:    addr = ADDR_MAP.min1;
            4'd3:    addr = ADDR_MAP.min10;
            4'd4:    addr = ADDR_MAP.hour1;
            4'd5:    addr = ADDR_MAP.hour10;
            4'd6:    addr = ADDR_MAP.day1;
            4'd7:    addr = ADDR_MAP.day10;
            4'd8:    addr = ADDR_MAP.mon1;
            4'd9:    addr = ADDR_MAP.mon10;
            4'd10:   addr = ADDR_MAP.year1;
            4'd11:   addr = ADDR_MAP.year10;
            default: addr = ADDR_MAP.wday;
        endcase
    end

endmodule

// File: rtl/rtc_gap_timer.sv
module rtc_gap_timer #(
    parameter int GAP_CYC = 250
)(
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic last
);

    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;

    logic [CW-1:0] cnt_q;

    assign last = en && (cnt_q == CW'(GAP_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // R3: the idle gap is never cut short by the sequencer
    p_gap_full_r3: assert property (@(posedge clk) disable iff (rst)
        en && !last |=> en);

endmodule

// File: rtl/rtc_nibble_bank.sv
module rtc_nibble_bank
    import rtc_snap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  rtc_time_t  wr_time,
    input  logic       cap_en,
    input  logic [3:0] cap_idx,
    input  logic [3:0] cap_nib,
    input  logic [3:0] rd_idx,
    output logic [3:0] rd_nib,
    output rtc_time_t  out_time
);

    logic [6:0] fld_in  [NUM_FIELDS];
    logic [6:0] fld_out [NUM_FIELDS];
    logic [3:0] nib_load [NUM_STEPS];
    logic [3:0] nib_q    [NUM_STEPS];

    assign fld_in[0] = wr_time.sec;
    assign fld_in[1] = wr_time.min;
    assign fld_in[2] = wr_time.hour;
    assign fld_in[3] = wr_time.day;
    assign fld_in[4] = wr_time.mon;
    assign fld_in[5] = wr_time.year % 7'd100;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [7:0] bcd;
        assign bcd             = bin_to_bcd(fld_in[f]);
        assign nib_load[2*f]   = bcd[3:0];
        assign nib_load[2*f+1] = bcd[7:4];
        assign fld_out[f]      = bcd_to_bin(nib_q[2*f+1], nib_q[2*f]);
    end
    assign nib_load[NUM_STEPS-1] = wr_time.wday;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STEPS; i++) nib_q[i] <= '0;
        end else if (load_en) begin
            for (int i = 0; i < NUM_STEPS; i++) nib_q[i] <= nib_load[i];
        end else if (cap_en) begin
            for (int i = 0; i < NUM_STEPS; i++)
                if (cap_idx == 4'(i)) nib_q[i] <= cap_nib;
        end
    end

    always_comb begin
        rd_nib = '0;
        for (int i = 0; i < NUM_STEPS; i++)
            if (rd_idx == 4'(i)) rd_nib = nib_q[i];
    end

    assign out_time = '{sec: fld_out[0], min: fld_out[1], hour: fld_out[2],
                        day: fld_out[3], mon: fld_out[4], year: fld_out[5],
                        wday: nib_q[NUM_STEPS-1]};

    // R6: captures only land on existing nibble slots
    p_cap_range_r6: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> cap_idx < 4'(NUM_STEPS));
    // R7: a new write image is never loaded during a read capture
    p_load_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(load_en && cap_en));

endmodule

// File: rtl/rtc_snap_seq.sv
module rtc_snap_seq
    import rtc_snap_pkg::*;
#(
    parameter rtc_addr_map_t ADDR_MAP  = RTC_DEFAULT_MAP,
    parameter logic [3:0]    CTRL_BASE = 4'h2,
    parameter int            BUSY_BIT  = 0,
    parameter int            MAX_TRIES = 10,
    parameter int            GAP_CYC   = 250
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       write,
    input  logic [6:0] wr_sec,
    input  logic [6:0] wr_min,
    input  logic [6:0] wr_hour,
    input  logic [6:0] wr_day,
    input  logic [6:0] wr_mon,
    input  logic [6:0] wr_year,
    input  logic [3:0] wr_wday,
    output logic [6:0] rd_sec,
    output logic [6:0] rd_min,
    output logic [6:0] rd_hour,
    output logic [6:0] rd_day,
    output logic [6:0] rd_mon,
    output logic [6:0] rd_year,
    output logic [3:0] rd_wday,
    output logic       done,
    output logic       err,
    output logic       ce,
    output logic       acc_req,
    output logic       acc_wr,
    output logic [3:0] acc_addr,
    output logic [3:0] acc_wdata,
    input  logic       acc_done,
    input  logic [3:0] acc_rdata
);

    localparam int TW        = $clog2(MAX_TRIES + 1);
    localparam int LAST_STEP = NUM_STEPS - 1;

    seq_state_e    state_q;
    logic [TW-1:0] tries_q;
    logic [3:0]    step_q;
    logic          op_wr_q;
    logic          err_q;
    logic          valid_q;

    rtc_time_t  wr_time;
    rtc_time_t  rd_time;
    logic [3:0] step_addr;
    logic [3:0] bank_nib;
    logic       gap_last;
    logic       in_link;
    logic       accept;

    assign wr_time = '{sec: wr_sec, min: wr_min, hour: wr_hour, day: wr_day,
                       mon: wr_mon, year: wr_year, wday: wr_wday};
    assign accept  = (state_q == ST_IDLE) && start;

    rtc_step_map #(.ADDR_MAP(ADDR_MAP)) i_map (
        .step (step_q),
        .addr (step_addr)
    );

    rtc_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q == ST_GAP),
        .last (gap_last)
    );

    rtc_nibble_bank i_bank (
        .clk      (clk),
        .rst      (rst),
        .load_en  (accept && write),
        .wr_time  (wr_time),
        .cap_en   ((state_q == ST_XFER) && acc_done && !op_wr_q),
        .cap_idx  (step_q),
        .cap_nib  (acc_rdata),
        .rd_idx   (step_q),
        .rd_nib   (bank_nib),
        .out_time (rd_time)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tries_q <= '0;
            step_q  <= '0;
            op_wr_q <= 1'b0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_wr_q <= write;
                        tries_q <= '0;
                        step_q  <= '0;
                        if (!write && !valid_q) begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end else begin
                            err_q   <= 1'b0;
                            state_q <= ST_CTRL_WR;
                        end
                    end
                end
                ST_CTRL_WR: begin
                    if (acc_done) state_q <= ST_CTRL_RD;
                end
                ST_CTRL_RD: begin
                    if (acc_done) begin
                        if (!acc_rdata[BUSY_BIT]) begin
                            step_q  <= '0;
                            state_q <= ST_XFER;
                        end else if (tries_q == TW'(MAX_TRIES - 1)) begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            state_q <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_last) state_q <= ST_CTRL_WR;
                end
                ST_XFER: begin
                    if (acc_done) begin
                        if (step_q == 4'(LAST_STEP)) state_q <= ST_FINISH;
                        else                         step_q  <= step_q + 1'b1;
                    end
                end
                ST_FINISH: begin
                    if (op_wr_q && !err_q) valid_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_link   = (state_q == ST_CTRL_WR) || (state_q == ST_CTRL_RD) || (state_q == ST_XFER);
    assign ce        = in_link;
    assign acc_req   = in_link;
    assign acc_wr    = (state_q == ST_CTRL_WR) || ((state_q == ST_XFER) && op_wr_q);
    assign acc_addr  = (state_q == ST_XFER) ? step_addr : ADDR_MAP.ctrl;
    assign acc_wdata = (state_q == ST_XFER) ? bank_nib  : CTRL_BASE;
    assign done      = (state_q == ST_FINISH);
    assign err       = err_q;

    assign rd_sec  = rd_time.sec;
    assign rd_min  = rd_time.min;
    assign rd_hour = rd_time.hour;
    assign rd_day  = rd_time.day;
    assign rd_mon  = rd_time.mon;
    assign rd_year = rd_time.year;
    assign rd_wday = rd_time.wday;

    // R11: an unacknowledged request keeps its command stable
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        acc_req && !acc_done |=> acc_req && $stable(acc_wr) && $stable(acc_addr) && $stable(acc_wdata));
    // R2: each attempt opens with the control register write
    p_attempt_opens_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ce) |-> acc_wr && (acc_addr == ADDR_MAP.ctrl) && (acc_wdata == CTRL_BASE));
    // R1: read without valid time is refused at once
    p_refuse_r1: assert property (@(posedge clk) disable iff (rst)
        accept && !write && !valid_q |=> done && err);
    // R9: a clean write marks the time valid
    p_valid_set_r9: assert property (@(posedge clk) disable iff (rst)
        done && !err && op_wr_q |=> valid_q);
    // R4: attempt counter stays within the retry budget
    p_try_bound_r4: assert property (@(posedge clk) disable iff (rst)
        tries_q < TW'(MAX_TRIES));

endmodule

// File: tb/test_rtc_snap_seq.sv
module test_rtc_snap_seq;

    localparam int GAP   = 250;
    localparam int TRIES = 10;
    localparam logic [3:0] CTRL_A = 4'hF;
    localparam logic [3:0] BASE   = 4'h2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic write = 1'b0;
    logic [6:0] wr_sec = '0, wr_min = '0, wr_hour = '0, wr_day = '0, wr_mon = '0, wr_year = '0;
    logic [3:0] wr_wday = '0;
    logic [6:0] rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year;
    logic [3:0] rd_wday;
    logic done, err, ce, acc_req, acc_wr;
    logic [3:0] acc_addr, acc_wdata;
    logic acc_done = 1'b0;
    logic [3:0] acc_rdata = '0;

    always #2 clk = ~clk;

    rtc_snap_seq i_rtc_snap_seq (
        .clk(clk), .rst(rst), .start(start), .write(write),
        .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_day(wr_day),
        .wr_mon(wr_mon), .wr_year(wr_year), .wr_wday(wr_wday),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_day(rd_day),
        .rd_mon(rd_mon), .rd_year(rd_year), .rd_wday(rd_wday),
        .done(done), .err(err), .ce(ce),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata)
    );

    int compared = 0;
    int mismatched = 0;

    // device model state
    logic [3:0] dev_reg [16];
    int busy_left = 0;
    int lat = 0;
    int wcnt = 0;
    int ce_viol = 0;
    int log_n = 0;
    logic       log_wr [64];
    logic [3:0] log_a  [64];
    logic [3:0] log_d  [64];
    int lowrun = 0;
    int last_gap = 0;
    bit seen_ce = 1'b0;
    int cyc = 0;
    int vals [7];

    always @(posedge clk) begin
        acc_done <= 1'b0;
        if (acc_req && !acc_done) begin
            if (wcnt >= lat) begin
                wcnt <= 0;
                acc_done <= 1'b1;
                if (!ce) ce_viol <= ce_viol + 1;
                if (log_n < 64) begin
                    log_wr[log_n] <= acc_wr;
                    log_a[log_n]  <= acc_addr;
                    log_d[log_n]  <= acc_wdata;
                end
                log_n <= log_n + 1;
                if (acc_wr) begin
                    if (acc_addr != CTRL_A) dev_reg[acc_addr] <= acc_wdata;
                end else if (acc_addr == CTRL_A) begin
                    if (busy_left > 0) begin
                        acc_rdata <= BASE | 4'h1;
                        busy_left <= busy_left - 1;
                    end else begin
                        acc_rdata <= BASE;
                    end
                end else begin
                    acc_rdata <= dev_reg[acc_addr];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (ce) begin
            if (seen_ce && lowrun != 0) last_gap <= lowrun;
            lowrun  <= 0;
            seen_ce <= 1'b1;
        end else if (seen_ce) begin
            lowrun <= lowrun + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    function automatic logic [3:0] step_addr(input int s);
        if (s < 6)       return 4'(s);
        else if (s < 12) return 4'(s + 1);
        else             return 4'h6;
    endfunction

    function automatic int exp_nib(input int s);
        int v;
        if (s == 12) return vals[6] & 15;
        v = vals[s / 2];
        if (s / 2 == 5) v = v % 100;
        return (s % 2 == 1) ? ((v / 10) & 15) : (v % 10);
    endfunction

    // one command; returns observed err
    task automatic run_op(input bit wr, input int busy, output bit got_err);
        int n;
        @(negedge clk);
        log_n = 0; seen_ce = 1'b0; last_gap = 0; ce_viol = 0;
        busy_left = busy; lat = $urandom_range(0, 2);
        write = wr;
        wr_sec = 7'(vals[0]); wr_min = 7'(vals[1]); wr_hour = 7'(vals[2]);
        wr_day = 7'(vals[3]); wr_mon = 7'(vals[4]); wr_year = 7'(vals[5]);
        wr_wday = 4'(vals[6]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 8000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 done seen", int'(done), 1);
        got_err = err;
        @(negedge clk);
        chk("R8 done single pulse", int'(done), 0);
        chk("R8 ce low after end", int'(ce), 0);
    endtask

    task automatic check_log(input bit wr, input int n_att, input bit fields);
        int e;
        chk("R5 access count", log_n, 2 * n_att + (fields ? 13 : 0));
        chk("R2 ce high on every access", ce_viol, 0);
        for (int a = 0; a < n_att; a++) begin
            chk("R2 control write", {int'(log_wr[2*a]), int'(log_a[2*a]), int'(log_d[2*a])},
                {1, int'(CTRL_A), int'(BASE)});
            chk("R2 control read", {int'(log_wr[2*a+1]), int'(log_a[2*a+1])}, {0, int'(CTRL_A)});
        end
        if (fields) begin
            for (int s = 0; s < 13; s++) begin
                e = 2 * n_att + s;
                chk("R5 field order", {int'(log_wr[e]), int'(log_a[e])}, {int'(wr), int'(step_addr(s))});
                if (wr) chk("R7 field data", int'(log_d[e]), exp_nib(s));
            end
        end
        if (n_att > 1) chk("R3 gap length", last_gap, GAP);
    endtask

    task automatic do_write(input int busy);
        bit e;
        bit ok;
        ok = (busy < TRIES);
        run_op(1'b1, busy, e);
        chk("R4 write status", int'(e), ok ? 0 : 1);
        check_log(1'b1, ok ? busy + 1 : TRIES, ok);
    endtask

    task automatic do_read(input int busy);
        bit e;
        int t [13];
        for (int s = 0; s < 13; s++) begin
            t[s] = (s == 12) ? $urandom_range(0, 15) : $urandom_range(0, 9);
            dev_reg[step_addr(s)] = 4'(t[s]);
        end
        run_op(1'b0, busy, e);
        chk("R9 read allowed", int'(e), 0);
        check_log(1'b0, busy + 1, 1'b1);
        chk("R6 sec",  int'(rd_sec),  t[1] * 10 + t[0]);
        chk("R6 min",  int'(rd_min),  t[3] * 10 + t[2]);
        chk("R6 hour", int'(rd_hour), t[5] * 10 + t[4]);
        chk("R6 day",  int'(rd_day),  t[7] * 10 + t[6]);
        chk("R6 mon",  int'(rd_mon),  t[9] * 10 + t[8]);
        chk("R6 year", int'(rd_year), t[11] * 10 + t[10]);
        chk("R6 wday", int'(rd_wday), t[12]);
    endtask

    task automatic random_vals();
        vals[0] = $urandom_range(0, 59); vals[1] = $urandom_range(0, 59);
        vals[2] = $urandom_range(0, 23); vals[3] = $urandom_range(1, 31);
        vals[4] = $urandom_range(1, 12); vals[5] = $urandom_range(0, 99);
        vals[6] = $urandom_range(0, 6);
    endtask

    initial begin
        bit e;
        int n0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) dev_reg[i] = '0;
        vals = '{0, 0, 0, 1, 1, 0, 0};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset ce", int'(ce), 0);
        chk("R11 reset req", int'(acc_req), 0);

        // R1: read refused before any valid time
        run_op(1'b0, 0, e);
        chk("R1 refused status", int'(e), 1);
        chk("R1 no access", log_n, 0);

        // R4: permanently busy write fails; R3 gap measured
        vals = '{10, 20, 3, 4, 5, 6, 1};
        do_write(TRIES);

        // R9: failed write leaves reads refused
        run_op(1'b0, 0, e);
        chk("R9 still refused", int'(e), 1);
        chk("R9 no access", log_n, 0);

        // R7 directed extremes, then year above 99
        vals = '{59, 0, 23, 31, 12, 99, 6};
        do_write(0);
        vals = '{0, 59, 0, 1, 1, 123, 15};
        do_write(9);

        // R10: start during a command is ignored
        random_vals();
        @(negedge clk);
        log_n = 0; seen_ce = 1'b0; busy_left = 0; lat = 1;
        write = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        write = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n0 = 0;
        while (!done && n0 < 8000) begin
            @(negedge clk);
            n0++;
        end
        chk("R10 first command only", log_n, 2 + 13);
        repeat (30) @(negedge clk);
        chk("R10 no second command", log_n, 2 + 13);

        // constrained random mix
        for (int k = 0; k < 10; k++) begin
            random_vals();
            if ($urandom_range(0, 1) == 1) do_write($urandom_range(0, 3));
            else                           do_read($urandom_range(0, 3));
        end
        do_read(9);

        finish_run();
    end

endmodule